// File: doc/BRIEF.md
# Weighted Modulo 2^K+1 Squarer

This block squares a residue modulo 2^K+1 in a single combinational pass. The operand is a K+1 bit unsigned value in plain binary, legal from 0 up to and including 2^K, and the result is a K+1 bit residue in the same range. It suits residue-number datapaths and modular exponentiation loops that work on the 2^K+1 channel directly. Zero is an ordinary input, and no translation is needed at the input or the output.

Internally the bit products of the operand form a symmetric matrix. Each product whose weight reaches 2^K is placed at its reduced column in inverted form. Equal twin products collapse into one bit one column to the left, and a twin that would leave the top column re-enters at column 0 inverted. For even K, one full adder per even column first makes all columns the same height. The remaining rows, plus a constant row with the value 2, pass through a chain of carry-save stages. In each stage the carry leaving the top column comes back inverted into column 0. A parallel-prefix adder with an inverted end-around carry adds the last two vectors and contributes the final +1. The top result bit is the group propagate of that adder.

Top module: `sqm_squarer`

## Requirements
- R1: For every operand A with 0 <= A <= 2^K, output `sq` equals (A*A) mod (2^K+1).
- R2: A = 0 gives 0, and A = 2^K (only bit K set) gives 1.
- R3: A = 2^K-1 gives 4.
- R4: Bit K of `sq` is 1 only when the result is exactly 2^K, with bits K-1..0 all zero. For K=4, A=4 and A=13 both give 16, and for K=8, A=16 gives 256.
- R5: The same RTL gives correct results for odd and even K (K=5, and K=4 and K=8) across every legal operand.
- R6: The block holds no state. `sq` follows a change of `op` with no clock edge in between.
- R7: A and 2^K+1-A give the same result for 1 <= A <= 2^K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | K+1 | Operand in weighted binary, 0..2^K |
| sq | output | K+1 | Square of `op` modulo 2^K+1, 0..2^K |

## Verification
Every result is due zero cycles after its stimulus: `sq` is a combinational function of `op`. The bench therefore drives `op` and samples `sq` one nanosecond later, always between clock edges, so that no edge and no process ordering can affect a sample. The zero-latency check drives a new operand just after a rising edge and reads the result well before the next edge. Odd and even widths are swept over every legal operand against a square-and-reduce model computed in the bench.

// File: rtl/sqm_pkg.sv
package sqm_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    function automatic gp_t gp_make(input logic x, input logic y);
        gp_t r;
        r.g = x & y;
        r.p = x ^ y;
        return r;
    endfunction

    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = hi.g | (hi.p & lo.g);
        r.p = hi.p & lo.p;
        return r;
    endfunction

    // column a folded product bit lands in
    function automatic int pp_col(input int k, input int i, input int j);
        int c;
        c = (i + j) % k;
        if (i != j) begin
            c = c + 1;
            if (c == k) c = 0;
        end
        return c;
    endfunction

    // whether the folded product bit is stored inverted
    function automatic bit pp_inv(input int k, input int i, input int j);
        bit v;
        v = ((i + j) >= k);
        if ((i != j) && (((i + j) % k) == (k - 1))) v = !v;
        return v;
    endfunction

    // enumeration index of the product (i,j), i <= j
    function automatic int pp_idx(input int k, input int i, input int j);
        int n;
        n = 0;
        for (int a = 0; a < k; a++) begin
            for (int b = a; b < k; b++) begin
                if ((a == i) && (b == j)) return n;
                n++;
            end
        end
        return 0;
    endfunction

    // index of the product found at a given column and slot
    function automatic int pp_at(input int k, input int col, input int slot);
        int n;
        int cnt;
        n = 0;
        cnt = 0;
        for (int a = 0; a < k; a++) begin
            for (int b = a; b < k; b++) begin
                if (pp_col(k, a, b) == col) begin
                    if (cnt == slot) return n;
                    cnt++;
                end
                n++;
            end
        end
        return 0;
    endfunction

    // constant row needed so that the chain plus the adder's +1 lands on A*A
    function automatic longint corr_row(input int k);
        longint m;
        longint d;
        longint stg;
        longint t;
        m = (longint'(1) << k) + 1;
        d = 0;
        for (int a = 0; a < k; a++) begin
            for (int b = a; b < k; b++) begin
                if (pp_inv(k, a, b)) d = d + (longint'(1) << pp_col(k, a, b));
            end
        end
        stg = longint'((k + 1) / 2) - 1;
        t = (d + stg + 1) % m;
        return (m - t) % m;
    endfunction

endpackage

// File: rtl/sqm_fold.sv
module sqm_fold #(
    parameter int K  = 8,
    parameter int NR = (K + 1) / 2
) (
    input  logic [K:0]            op,
    output wire  [NR-1:0][K-1:0]  rows
);
    import sqm_pkg::*;

    localparam int NT = K * (K + 1) / 2;

    wire [NT-1:0] terms;

    // product bits, inverted where their weight wrapped past 2^K
    for (genvar gi = 0; gi < K; gi++) begin : g_i
        for (genvar gj = gi; gj < K; gj++) begin : g_j
            localparam int IDX = pp_idx(K, gi, gj);
            localparam bit INV = pp_inv(K, gi, gj);
            logic b;
            if ((gi == 0) && (gj == 0)) begin : g_d0
                assign b = op[0] | op[K];
            end else if (gi == gj) begin : g_dg
                assign b = op[gi];
            end else begin : g_pr
                assign b = op[gi] & op[gj];
            end
            assign terms[IDX] = INV ? ~b : b;
        end
    end

    if ((K % 2) == 1) begin : g_odd
        for (genvar c = 0; c < K; c++) begin : g_c
            for (genvar s = 0; s < NR; s++) begin : g_s
                assign rows[s][c] = terms[pp_at(K, c, s)];
            end
        end
    end else begin : g_even
        for (genvar c = 0; c < K; c++) begin : g_c
            for (genvar s = 0; s < NR - 1; s++) begin : g_s
                assign rows[s][c] = terms[pp_at(K, c, s)];
            end
            if ((c % 2) == 0) begin : g_fa
                localparam int XI = pp_at(K, c, NR - 1);
                localparam int YI = pp_at(K, c, NR);
                localparam int ZI = pp_at(K, c, NR + 1);
                assign rows[NR-1][c]   = terms[XI] ^ terms[YI] ^ terms[ZI];
                assign rows[NR-1][c+1] = (terms[XI] & terms[YI]) |
                                         (terms[XI] & terms[ZI]) |
                                         (terms[YI] & terms[ZI]);
            end
        end
    end

endmodule

// File: rtl/sqm_csa_eac.sv
module sqm_csa_eac #(
    parameter int K = 8
) (
    input  logic [K-1:0] x,
    input  logic [K-1:0] y,
    input  logic [K-1:0] z,
    output logic [K-1:0] s,
    output logic [K-1:0] c
);
    localparam longint M = (longint'(1) << K) + 1;

    logic [K-1:0] maj;

    assign maj = (x & y) | (x & z) | (y & z);
    assign s   = x ^ y ^ z;
    assign c   = {maj[K-2:0], ~maj[K-1]};

    // each stage adds exactly one to the residue of its three inputs (R1)
    always_comb begin
        if (!$isunknown({x, y, z, s, c})) begin
            assert_csa_residue_R1: assert (((longint'(s) + longint'(c)) % M) ==
                ((longint'(x) + longint'(y) + longint'(z) + 1) % M))
                else $error("csa stage residue off by other than one");
        end
    end

endmodule

// File: rtl/sqm_eac_adder.sv
module sqm_eac_adder #(
    parameter int K = 8
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    output logic [K:0]   res
);
    import sqm_pkg::*;

    localparam int     LV = $clog2(K);
    localparam longint M  = (longint'(1) << K) + 1;

    always_comb begin
        gp_t  base [K];
        gp_t  cur  [K];
        gp_t  nxt  [K];
        logic cin;
        for (int i = 0; i < K; i++) begin
            base[i] = gp_make(a[i], b[i]);
            cur[i]  = base[i];
        end
        for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < K; i++) begin
                if (i >= (1 << l)) nxt[i] = gp_merge(cur[i], cur[i - (1 << l)]);
                else               nxt[i] = cur[i];
            end
            cur = nxt;
        end
        // carry out returns inverted as a late carry-in
        cin    = ~cur[K-1].g;
        res[0] = base[0].p ^ cin;
        for (int i = 1; i < K; i++) begin
            res[i] = base[i].p ^ (cur[i-1].g | (cur[i-1].p & cin));
        end
        res[K] = cur[K-1].p;
    end

    always_comb begin
        if (!$isunknown({a, b, res})) begin
            assert_adder_plus_one_R1: assert (longint'(res) ==
                ((longint'(a) + longint'(b) + 1) % M))
                else $error("final adder result is not a+b+1 mod 2^K+1");
            assert_top_bit_alone_R4: assert (!res[K] || (res[K-1:0] == '0))
                else $error("result bit K set with nonzero low bits");
        end
    end

endmodule

// File: rtl/sqm_squarer.sv
module sqm_squarer #(
    parameter int K = 8
) (
    input  logic [K:0] op,
    output logic [K:0] sq
);
    import sqm_pkg::*;

    localparam int     NR     = (K + 1) / 2;
    localparam int     NIN    = NR + 1;
    localparam int     NST    = NIN - 2;
    localparam longint M      = (longint'(1) << K) + 1;
    localparam longint CORR_L = corr_row(K);

    wire [NR-1:0][K-1:0] rows;
    wire [K-1:0]         opnd [NIN];

    sqm_fold #(.K(K), .NR(NR)) u_fold (
        .op   (op),
        .rows (rows)
    );

    for (genvar r = 0; r < NR; r++) begin : g_opnd
        assign opnd[r] = rows[r];
    end
    assign opnd[NR] = CORR_L[K-1:0];

    for (genvar t = 0; t < NST; t++) begin : g_stg
        logic [K-1:0] x_in;
        logic [K-1:0] y_in;
        logic [K-1:0] s_o;
        logic [K-1:0] c_o;
        if (t == 0) begin : g_first
            assign x_in = opnd[0];
            assign y_in = opnd[1];
        end else begin : g_next
            assign x_in = g_stg[t-1].s_o;
            assign y_in = g_stg[t-1].c_o;
        end
        sqm_csa_eac #(.K(K)) u_csa (
            .x (x_in),
            .y (y_in),
            .z (opnd[t+2]),
            .s (s_o),
            .c (c_o)
        );
    end

    sqm_eac_adder #(.K(K)) u_add (
        .a   (g_stg[NST-1].s_o),
        .b   (g_stg[NST-1].c_o),
        .res (sq)
    );

    initial begin
        assert_width_range_R5: assert (K >= 3 && K <= 30)
            else $error("K outside supported range");
        assert_corr_row_two_R1: assert (CORR_L == 2)
            else $error("correction row is not the constant 2");
    end

    always_comb begin
        if (!$isunknown({op, sq}) && (longint'(op) < M)) begin
            assert_square_model_R1: assert (longint'(sq) ==
                ((longint'(op) * longint'(op)) % M))
                else $error("square residue mismatch");
            assert_zero_in_R2: assert ((op != '0) || (sq == '0))
                else $error("zero operand gave nonzero square");
            assert_top_in_R2: assert ((op != ((K+1)'(1) << K)) || (sq == (K+1)'(1)))
                else $error("operand 2^K did not give 1");
        end
    end

endmodule

// File: tb/sqm_squarer_tb.sv
module sqm_squarer_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [5:0] op5;
    logic [5:0] sq5;
    logic [4:0] op4;
    logic [4:0] sq4;
    logic [8:0] op8;
    logic [8:0] sq8;

    sqm_squarer #(.K(5)) u_dut  (.op(op5), .sq(sq5));
    sqm_squarer #(.K(4)) u_dut4 (.op(op4), .sq(sq4));
    sqm_squarer #(.K(8)) u_dut8 (.op(op8), .sq(sq8));

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam int NV = 12;
    localparam logic [5:0] VEC_IN  [NV] = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd5, 6'd6,
                                           6'd7, 6'd10, 6'd15, 6'd16, 6'd31, 6'd32};
    localparam logic [5:0] VEC_EXP [NV] = '{6'd0, 6'd1, 6'd4, 6'd9, 6'd25, 6'd3,
                                           6'd16, 6'd1, 6'd27, 6'd25, 6'd4, 6'd1};

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int held;
        op5 = '0;
        op4 = '0;
        op8 = '0;
        @(negedge clk);
        #1;
        // R2: initial zero operand on every width
        chk("R2", "K=5 zero", int'(sq5), 0);
        chk("R2", "K=4 zero", int'(sq4), 0);
        chk("R2", "K=8 zero", int'(sq8), 0);

        // R1: vector table for K=5
        for (int v = 0; v < NV; v++) begin
            op5 = VEC_IN[v];
            #1;
            chk("R1", $sformatf("table K=5 op=%0d", VEC_IN[v]), int'(sq5), int'(VEC_EXP[v]));
        end

        // R1: every legal operand at K=5 (odd width)
        for (int a = 0; a <= 32; a++) begin
            op5 = 6'(a);
            #1;
            chk("R1", $sformatf("sweep K=5 op=%0d", a), int'(sq5), (a * a) % 33);
        end

        // R5: every legal operand at even widths
        for (int a = 0; a <= 16; a++) begin
            op4 = 5'(a);
            #1;
            chk("R5", $sformatf("sweep K=4 op=%0d", a), int'(sq4), (a * a) % 17);
        end
        for (int a = 0; a <= 256; a++) begin
            op8 = 9'(a);
            #1;
            chk("R5", $sformatf("sweep K=8 op=%0d", a), int'(sq8), (a * a) % 257);
        end

        // R2: only the top input bit set
        op5 = 6'd32; op4 = 5'd16; op8 = 9'd256;
        #1;
        chk("R2", "K=5 op=2^K", int'(sq5), 1);
        chk("R2", "K=4 op=2^K", int'(sq4), 1);
        chk("R2", "K=8 op=2^K", int'(sq8), 1);

        // R3: all low bits set
        op5 = 6'd31; op4 = 5'd15; op8 = 9'd255;
        #1;
        chk("R3", "K=5 op=2^K-1", int'(sq5), 4);
        chk("R3", "K=4 op=2^K-1", int'(sq4), 4);
        chk("R3", "K=8 op=2^K-1", int'(sq8), 4);

        // R4: result 2^K is the only one with the top bit
        op4 = 5'd4; op8 = 9'd16;
        #1;
        chk("R4", "K=4 op=4", int'(sq4), 16);
        chk("R4", "K=8 op=16", int'(sq8), 256);
        op4 = 5'd13;
        #1;
        chk("R4", "K=4 op=13", int'(sq4), 16);
        op4 = 5'd5;
        #1;
        chk("R4", "K=4 op=5 top bit", int'(sq4[4]), 0);

        // R6: result follows the operand between clock edges
        @(posedge clk);
        #1;
        op5 = 6'd7;
        #1;
        chk("R6", "K=5 op=7 before next edge", int'(sq5), 16);
        op5 = 6'd6;
        #1;
        chk("R6", "K=5 op=6 before next edge", int'(sq5), 3);

        // R7: A and 2^K+1-A square alike
        for (int a = 1; a <= 32; a++) begin
            op5 = 6'(a);
            #1;
            held = int'(sq5);
            op5 = 6'(33 - a);
            #1;
            chk("R7", $sformatf("K=5 op=%0d vs %0d", a, 33 - a), int'(sq5), held);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule